// File: doc/BRIEF.md
# Dual-Select Byte-Wide Asynchronous SRAM Core

This block is a byte-wide static memory driven by pins that have no clock of their own: an address bus, an active-low select, an active-high select, an active-low write strobe, an active-low output enable and a bidirectional data bus. The controls are sampled on a fast internal clock, so the whole block can be synthesized. From the sampled controls the block works out one of four modes: deselected, selected with outputs off, writing, or reading. It then either drives the data bus or leaves it floating.

A write is open only while three conditions hold at once: the low select is low, the high select is high, and the write strobe is low. The write is committed when that window closes, whichever of the three ends it. The stored byte and address are the values sampled in the last internal cycle before the close. Internally the tri-state driver is a data-out vector plus a drive-enable. The top level joins them onto an inout bus and also brings the drive-enable out as a port. The array depth is a parameter. A reduced array is indexed by the low address bits, and the higher bits alias.

Top module: `sram_dualsel_core`

## Requirements
- R1: When the low select is high or the high select is low, the block does not drive the data bus (`dq_drive_o` = 0), whatever the write strobe and output enable are.
- R2: While both selects are active and the write strobe is low, the bus is not driven, even with the output enable low.
- R3: With both selects active, the write strobe high and the output enable low, the bus carries the stored byte at the addressed location, and `dq_drive_o` = 1.
- R4: With both selects active and both the write strobe and the output enable high, the bus is not driven.
- R5: A write window closed by the write strobe rising stores the bus byte into the addressed location.
- R6: A write window closed by the low select rising commits the write in the same way.
- R7: A write window closed by the high select falling commits the write in the same way.
- R8: Write strobe pulses while the device is deselected (either select inactive) leave the array unchanged.
- R9: The array location is the low `MEM_AW` bits of the address. Addresses that differ only in higher bits reach the same byte.
- R10: Pin changes reach the outputs after two internal clock edges. While reset is held, and right after it, the bus is not driven.
- R11: If the bus byte changes while a write window is open, only the value present in the final sampled cycle of the window is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Location address |
| cs_n_i | input | 1 | Select, active low |
| cs_i | input | 1 | Select, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dq_io | inout | DATA_W | Bidirectional data bus |
| dq_drive_o | output | 1 | High while the block drives `dq_io` |

## Verification
The bench closes write windows in three ways: through the write strobe, the low select and the high select. A design that captured data only on the strobe edge would lose the select-terminated writes. It also changes the bus byte in the middle of a window. A design that latched data at the window start would store the stale byte.

Writes with the output enable held low check that the drivers stay off. A design that decoded reads from the output enable alone would fight the bus. Strobe pulses while deselected must not reach the array. Aliased addresses must land on the same byte, so a wrong index slice shows up as a mismatch. Random traffic is then compared against a reference array kept in the bench.

// File: rtl/sram_dualsel_pkg.sv
package sram_dualsel_pkg;

  // bit positions inside the synchronised control vector
  localparam int CTL_W    = 4;
  localparam int CTL_SELN = 3;
  localparam int CTL_SEL  = 2;
  localparam int CTL_WEN  = 1;
  localparam int CTL_OEN  = 0;

  // idle level of the control pins: deselected, strobes inactive
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUTOFF  = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_READ    = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] nxt;
      logic [W-1:0] r;
      if (i == 0) begin : g_first
        assign nxt = d_i;
      end else begin : g_rest
        assign nxt = g_stg[i-1].r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= nxt;
      end
    end
  endgenerate

  assign q_o = g_stg[STAGES-1].r;

endmodule

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_dualsel_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] s_ctrl_i,
  input  logic [AW-1:0]    s_addr_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             drive_en_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [AW-1:0]    rd_addr_o
);

  sram_mode_e  mode;
  logic        sel_ok;
  logic        win_now;

  logic          win_q,  win_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          cap_en;

  // mode decode
  always_comb begin
    sel_ok = !s_ctrl_i[CTL_SELN] && s_ctrl_i[CTL_SEL];
    if (!sel_ok)                  mode = MODE_STANDBY;
    else if (!s_ctrl_i[CTL_WEN])  mode = MODE_WRITE;
    else if (!s_ctrl_i[CTL_OEN])  mode = MODE_READ;
    else                          mode = MODE_OUTOFF;
  end

  assign win_now = (mode == MODE_WRITE);

  // next-state: hold the last sample taken inside the window
  always_comb begin
    cap_en = win_now;
    win_d  = win_now;
    addr_d = addr_q;
    data_d = data_q;
    if (cap_en) begin
      addr_d = s_addr_i;
      data_d = s_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      win_q  <= win_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  // commit on the falling edge of the window term
  assign wr_en_o    = win_q && !win_now;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign rd_addr_o  = s_addr_i;
  assign drive_en_o = (mode == MODE_READ);

endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/sram_dualsel_core.sv
module sram_dualsel_core
  import sram_dualsel_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              cs_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  inout  wire  [DATA_W-1:0] dq_io,
  output logic              dq_drive_o
);

  localparam int IDX_W = (MEM_AW < ADDR_W) ? MEM_AW : ADDR_W;

  logic              rst_sync_n;
  logic [CTL_W-1:0]  s_ctrl;
  logic [IDX_W-1:0]  s_addr;
  logic [DATA_W-1:0] s_data;
  logic              drive_en;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;

  generate
    if (IDX_W < ADDR_W) begin : g_alias
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_i[ADDR_W-1:IDX_W];
    end
  endgenerate

  sram_pin_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  sram_pin_sync #(.W(CTL_W), .STAGES(SYNC_N), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d_i({cs_n_i, cs_i, we_n_i, oe_n_i}),
    .q_o(s_ctrl)
  );

  sram_pin_sync #(.W(IDX_W + DATA_W), .STAGES(SYNC_N), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d_i({addr_i[IDX_W-1:0], dq_io}),
    .q_o({s_addr, s_data})
  );

  sram_mode_decode #(.AW(IDX_W), .DW(DATA_W)) u_decode (
    .clk(clk), .rst_n(rst_sync_n),
    .s_ctrl_i(s_ctrl), .s_addr_i(s_addr), .s_data_i(s_data),
    .drive_en_o(drive_en), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr)
  );

  sram_cell_array #(.AW(IDX_W), .DW(DATA_W)) u_array (
    .clk(clk), .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  // tri-state wrapper
  assign dq_io      = drive_en ? rd_data : {DATA_W{1'bz}};
  assign dq_drive_o = drive_en;

endmodule

// File: rtl/sram_dualsel_core_chk.sv
module sram_dualsel_core_chk
  import sram_dualsel_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] s_ctrl,
  input logic             drive_en,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [DW-1:0]    rd_data
);

  logic sel_ok;
  assign sel_ok = !s_ctrl[CTL_SELN] && s_ctrl[CTL_SEL];

  p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> !drive_en);

  p_write_nodrive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !s_ctrl[CTL_WEN]) |-> !drive_en);

  p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && s_ctrl[CTL_WEN] && !s_ctrl[CTL_OEN]) |-> drive_en);

  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && s_ctrl[CTL_WEN] && s_ctrl[CTL_OEN]) |-> !drive_en);

  p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_commit_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data))));

endmodule

bind sram_dualsel_core sram_dualsel_core_chk #(.AW(IDX_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .s_ctrl(s_ctrl), .drive_en(drive_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sram_dualsel_core_tb.sv
module sram_dualsel_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 8;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int N_RAND = 300;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              cs_n, cs, we_n, oe_n;
  logic              tb_drv;
  logic [DATA_W-1:0] tb_val;
  wire  [DATA_W-1:0] dq;
  wire               drv;

  assign dq = tb_drv ? tb_val : {DATA_W{1'bz}};

  sram_dualsel_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n), .cs_i(cs),
    .we_n_i(we_n), .oe_n_i(oe_n), .dq_io(dq), .dq_drive_o(drv)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [DATA_W-1:0] ref_mem [DEPTH];
  bit                ref_ok  [DEPTH];

  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return int'(a[MEM_AW-1:0]);
  endfunction

  function automatic logic exp_drive(input logic sn, input logic s, input logic wn, input logic on);
    return !sn && s && wn && !on;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 1'b1; cs = 1'b0; we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
  endtask

  // end_kind: 0 strobe rises (R5), 1 low select rises (R6), 2 high select falls (R7)
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input int end_kind, input bit oe_low, input bit mid,
                          input logic [DATA_W-1:0] d_early);
    addr = a; tb_drv = 1'b1; tb_val = mid ? d_early : d;
    cs_n = 1'b0; cs = 1'b1; we_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
    step(3);
    check(drv == 1'b0, "R2 drivers off in write", 32'(drv), 32'(0));
    if (mid) tb_val = d;   // R11: late byte must win
    step(3);
    case (end_kind)
      0:       we_n = 1'b1;
      1:       cs_n = 1'b1;
      default: cs   = 1'b0;
    endcase
    tb_drv = 1'b0;
    step(1);
    go_idle();
    step(4);
    ref_mem[idx_of(a)] = d;
    ref_ok[idx_of(a)]  = 1'b1;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    logic [DATA_W-1:0] got;
    logic              dv;
    addr = a; cs_n = 1'b0; cs = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    step(1);
    check(drv == 1'b0, "R10 one edge not enough", 32'(drv), 32'(0));
    step(1);
    dv = drv; got = dq;
    check(dv == exp_drive(1'b0, 1'b1, 1'b1, 1'b0), "R3 read drives bus", 32'(dv), 32'(1));
    if (ref_ok[idx_of(a)])
      check(got == ref_mem[idx_of(a)], req, 32'(got), 32'(ref_mem[idx_of(a)]));
    go_idle();
    step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", n_checks, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
    addr = '0; tb_val = '0;
    rst_n = 1'b0;
    // read conditions during reset: bus must stay undriven
    cs_n = 1'b0; cs = 1'b1; we_n = 1'b1; oe_n = 1'b0; tb_drv = 1'b0;
    step(4);
    check(drv == 1'b0, "R10 undriven in reset", 32'(drv), 32'(0));
    go_idle();
    step(1);
    rst_n = 1'b1;
    step(4);
    check(drv == 1'b0, "R10 undriven after reset", 32'(drv), 32'(0));

    // three ways to close the window
    do_write(18'h00005, 8'h3C, 0, 1'b0, 1'b0, 8'h00);
    do_read (18'h00005, "R5 strobe-ended write");
    do_write(18'h00011, 8'hA5, 1, 1'b0, 1'b0, 8'h00);
    do_read (18'h00011, "R6 low-select-ended write");
    do_write(18'h00022, 8'h5A, 2, 1'b1, 1'b0, 8'h00);
    do_read (18'h00022, "R7 high-select-ended write");

    // R11: byte changed mid-window
    do_write(18'h00030, 8'h81, 0, 1'b1, 1'b1, 8'h18);
    do_read (18'h00030, "R11 last byte wins");

    // R8: strobe pulses while deselected, both select styles
    for (int k = 0; k < 2; k++) begin
      addr = 18'h00005; tb_drv = 1'b1; tb_val = 8'hC3;
      cs_n = (k == 0) ? 1'b1 : 1'b0; cs = (k == 0) ? 1'b1 : 1'b0; oe_n = 1'b0;
      for (int p = 0; p < 3; p++) begin
        we_n = 1'b0; step(3);
        check(drv == 1'b0, "R1 deselected undriven", 32'(drv), 32'(0));
        we_n = 1'b1; step(3);
        check(drv == 1'b0, "R1 deselected undriven", 32'(drv), 32'(0));
      end
      go_idle(); step(4);
      do_read(18'h00005, "R8 no write while deselected");
    end

    // R4: read with output enable high
    addr = 18'h00005; cs_n = 1'b0; cs = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(4);
    check(drv == 1'b0, "R4 oe high undriven", 32'(drv), 32'(0));
    go_idle(); step(3);

    // R9: aliasing on upper address bits
    do_write(18'h20005, 8'h77, 0, 1'b0, 1'b0, 8'h00);
    do_read (18'h00005, "R9 alias low index");
    do_read (18'h3FFC5, "R9 alias high bits");

    // random traffic
    for (int n = 0; n < N_RAND; n++) begin
      logic [ADDR_W-1:0] ra;
      logic [DATA_W-1:0] rd, re;
      ra = ADDR_W'($urandom);
      rd = DATA_W'($urandom);
      re = DATA_W'($urandom);
      if ($urandom_range(0, 1) == 0)
        do_write(ra, rd, int'($urandom_range(0, 2)), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), re);
      else
        do_read(ra, "R3 random read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule